// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder Tree

This block adds N unsigned K-bit operands in one cycle. A tree of 3:2 carry-save rows cuts the operand count down level by level until two rows remain. A single carry-propagate adder then merges those two rows into the full-precision total. Each carry-save row keeps the carries in their own row and passes them down, so the delay of one level is one full-adder cell at any word width. The result is registered, and a valid flag follows the input flag one cycle later.

The operands arrive packed side by side in one flat input vector. The number of tree levels is worked out during elaboration from a recurrence. That recurrence gives the largest number of rows that h levels can bring down to two: 2, 3, 4, 6, 9, 13, 19. A parameter chooses how each level is scheduled. The greedy schedule compresses every complete group of three rows as soon as it appears. The deferred schedule compresses only as many groups as the next level's row budget requires. Both schedules use N−2 carry-save rows in total and give the same sum.

Top module: `csa_sum_tree`

## Requirements
- R1: One cycle after a clock edge that samples `in_valid` high, `sum` holds the exact unsigned total of all N operands. It is K + ceil(log2 N) bits wide (11 bits for N=7, K=8).
- R2: `out_valid` is `in_valid` delayed by one clock cycle.
- R3: While `rst` is high at a clock edge, `out_valid` and `sum` are cleared to zero on that edge.
- R4: A clock edge that samples `in_valid` low leaves `sum` unchanged, whatever the operand input holds.
- R5: Every 3:2 row turns inputs x, y, z into a sum row s and a carry row c such that x + y + z = s + 2·c.
- R6: When every operand is all ones, `sum` equals N·(2^K − 1) with no loss of the top bits (1785 for N=7, K=8).
- R7: Operand i occupies bits [i·K +: K] of `operands`. A single non-zero operand in any slot gives exactly that operand's value as the sum.
- R8: With `DEFER_MODE`=1 (deferred schedule), the block returns the same sum and valid timing as with `DEFER_MODE`=0 (greedy schedule) for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand vector is valid this cycle |
| operands | input | N·K | Packed operands, operand i at bits [i·K +: K] |
| out_valid | output | 1 | Registered sum is fresh |
| sum | output | K+clog2(N) | Registered full-precision total |

## Verification
A bad bit in any carry-save row, a dropped carry, or a wrong slot in the level schedule shows up on `sum` on the first edge that captures an affected operand pattern. The all-ones set drives every carry chain, and the single-slot patterns find operands that were passed to the wrong place. An error that only one schedule has appears as a disagreement between the greedy and deferred instances on the same vector. A slip in the valid pipeline or in the hold logic appears one cycle after the stimulus, as a wrong `out_valid` or a changed `sum`.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  // Largest row count that h carry-save levels can bring down to two rows.
  function automatic int max_rows(input int h);
    int m;
    m = 2;
    for (int i = 0; i < h; i++) m = (3 * m) / 2;
    return m;
  endfunction

  // Number of levels needed for n rows.
  function automatic int tree_levels(input int n);
    int h;
    h = 0;
    for (int i = 0; i < 16; i++)
      if (max_rows(i) < n) h = i + 1;
    return h;
  endfunction

  // Carry-save rows placed at level lvl under the chosen schedule.
  function automatic int csa_count(input int n, input int lvl, input int defer);
    int r, g, hs;
    r  = n;
    g  = 0;
    hs = tree_levels(n);
    for (int l = 0; l <= lvl; l++) begin
      if (defer != 0) begin
        g = r - max_rows(hs - l - 1);
        if (g < 0) g = 0;
        if (g > r / 3) g = r / 3;
      end else begin
        g = r / 3;
      end
      if (l < lvl) r = r - g;
    end
    return g;
  endfunction

  // Rows entering level lvl.
  function automatic int rows_in(input int n, input int lvl, input int defer);
    int r;
    r = n;
    for (int l = 0; l < lvl; l++) r = r - csa_count(n, l, defer);
    return r;
  endfunction

endpackage

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] maj;

  always_comb begin
    for (int b = 0; b < W; b++) begin
      s[b]   = x[b] ^ y[b] ^ z[b];
      maj[b] = (x[b] & y[b]) | (x[b] & z[b]) | (y[b] & z[b]);
    end
  end

  // Carry row is weighted one place up; the top carry cannot be set inside a
  // tree whose width already covers the whole total.
  assign c = {maj[W-2:0], 1'b0};

  always_comb begin
    assert_csa_identity_R5: assert (({2'b00, x} + {2'b00, y} + {2'b00, z}) ==
                                    ({2'b00, s} + {1'b0, maj, 1'b0}))
      else $error("carry-save identity broken");
  end
endmodule

// File: rtl/carry_prop_adder.sv
module carry_prop_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i]    = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  always_comb begin
    assert_cpa_exact_R1: assert (y == W'(a + b))
      else $error("ripple adder result wrong");
  end
endmodule

// File: rtl/csa_reduce.sv
module csa_reduce
  import csa_tree_pkg::*;
#(
  parameter int N     = 7,
  parameter int W     = 11,
  parameter int DEFER = 0
) (
  input  logic [N*W-1:0] rows_flat,
  output logic [W-1:0]   row_a,
  output logic [W-1:0]   row_b
);
  localparam int LEVELS = tree_levels(N);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int R = rows_in(N, l, DEFER);
    localparam int G = csa_count(N, l, DEFER);

    logic [W-1:0] cur [N];
    logic [W-1:0] nxt [N];

    if (l == 0) begin : g_src
      for (genvar i = 0; i < N; i++) begin : g_unpack
        assign cur[i] = rows_flat[i*W +: W];
      end
    end else begin : g_chain
      for (genvar i = 0; i < N; i++) begin : g_link
        assign cur[i] = g_lvl[l-1].nxt[i];
      end
    end

    for (genvar j = 0; j < N; j++) begin : g_slot
      if (j < G) begin : g_csa
        csa_row #(.W(W)) u_row (
          .x(cur[3*j]),
          .y(cur[3*j+1]),
          .z(cur[3*j+2]),
          .s(nxt[2*j]),
          .c(nxt[2*j+1])
        );
      end
      if (j >= 2*G && j < R - G) begin : g_pass
        assign nxt[j] = cur[j+G];
      end else if (j >= R - G) begin : g_idle
        assign nxt[j] = '0;
      end
    end
  end

  assign row_a = g_lvl[LEVELS-1].nxt[0];
  assign row_b = g_lvl[LEVELS-1].nxt[1];
endmodule

// File: rtl/csa_sum_tree.sv
module csa_sum_tree
  import csa_tree_pkg::*;
#(
  parameter int N          = 7,
  parameter int K          = 8,
  parameter int DEFER_MODE = 0,
  localparam int SW        = K + $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [N*K-1:0]  operands,
  output logic            out_valid,
  output logic [SW-1:0]   sum
);
  if (N < 3 || N > 19) begin : g_bad_n
    $error("N must lie in 3..19");
  end

  logic [N*SW-1:0] wide_rows;
  logic [SW-1:0]   red_a, red_b, total;

  for (genvar i = 0; i < N; i++) begin : g_widen
    assign wide_rows[i*SW +: SW] = {{(SW-K){1'b0}}, operands[i*K +: K]};
  end

  csa_reduce #(.N(N), .W(SW), .DEFER(DEFER_MODE)) u_reduce (
    .rows_flat(wide_rows),
    .row_a(red_a),
    .row_b(red_b)
  );

  carry_prop_adder #(.W(SW)) u_cpa (
    .a(red_a),
    .b(red_b),
    .y(total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) sum <= total;
    end
  end

  // Behavioural total, used only by the checks below.
  logic [SW-1:0] ref_total;
  always_comb begin
    ref_total = '0;
    for (int i = 0; i < N; i++) ref_total = ref_total + SW'(operands[i*K +: K]);
  end

  assert_sum_exact_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (sum == $past(ref_total)))
    else $error("registered sum differs from operand total");

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid)
    else $error("out_valid missing after in_valid");

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid)
    else $error("out_valid without in_valid");

  assert_sum_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sum))
    else $error("sum changed without in_valid");
endmodule

// File: tb/test_csa_sum_tree.sv
`timescale 1ns/1ps
module test_csa_sum_tree;
  localparam int N  = 7;
  localparam int K  = 8;
  localparam int SW = K + $clog2(N);
  localparam int NV = 9;

  // Stimulus (operand i at bits [i*8 +: 8]) and expected totals.
  localparam logic [N*K-1:0] STIM [NV] = '{
    56'h00_00_00_00_00_00_00,
    56'hFF_FF_FF_FF_FF_FF_FF,
    56'h07_06_05_04_03_02_01,
    56'h80_80_80_80_80_80_80,
    56'hFF_00_00_00_00_00_00,
    56'h00_00_00_00_00_00_01,
    56'h46_3C_32_28_1E_14_0A,
    56'hFF_00_FF_00_FF_00_FF,
    56'h4B_19_32_FA_96_C8_64
  };
  localparam int EXPECT [NV] = '{0, 1785, 28, 896, 255, 1, 280, 1020, 850};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [N*K-1:0]  operands = '0;
  logic            vld_g, vld_d;
  logic [SW-1:0]   sum_g, sum_d;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  csa_sum_tree #(.N(N), .K(K), .DEFER_MODE(0)) i_csa_sum_tree (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operands(operands),
    .out_valid(vld_g), .sum(sum_g)
  );

  csa_sum_tree #(.N(N), .K(K), .DEFER_MODE(1)) i_csa_sum_tree_defer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operands(operands),
    .out_valid(vld_d), .sum(sum_d)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_sum(input logic [N*K-1:0] v);
    int t = 0;
    for (int i = 0; i < N; i++) t += int'(v[i*K +: K]);
    return t;
  endfunction

  // Drive at a falling edge, capture on the next rising edge, sample at the
  // following falling edge.
  task automatic apply(input logic [N*K-1:0] v, input int exp, input string req);
    @(negedge clk);
    operands = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, int'(sum_g), exp);
    check("R8", int'(sum_d), exp);
    check("R2", int'(vld_g), 1);
  endtask

  initial begin
    // R3: reset clears outputs
    repeat (3) @(negedge clk);
    check("R3", int'(vld_g), 0);
    check("R3", int'(sum_g), 0);
    check("R3", int'(sum_d), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1, R6, R7: table walk
    for (int t = 0; t < NV; t++) begin
      string tag;
      tag = (t == 1) ? "R6" : ((t == 4 || t == 5) ? "R7" : "R1");
      apply(STIM[t], EXPECT[t], tag);
    end

    // R7: single non-zero operand in every slot
    for (int s = 0; s < N; s++) begin
      logic [N*K-1:0] v;
      v = '0;
      v[s*K +: K] = 8'(8'hA5 ^ s);
      apply(v, int'(8'hA5 ^ s), "R7");
    end

    // R1/R5: random sets with a behavioural reference
    for (int t = 0; t < 40; t++) begin
      logic [N*K-1:0] v;
      for (int i = 0; i < N; i++) v[i*K +: K] = 8'($urandom);
      apply(v, ref_sum(v), "R5");
    end

    // R4 and R2: held sum and low valid while in_valid is low
    apply(STIM[8], 850, "R1");
    @(negedge clk);
    operands = STIM[1];
    @(negedge clk);
    check("R4", int'(sum_g), 850);
    check("R4", int'(sum_d), 850);
    check("R2", int'(vld_g), 0);
    check("R2", int'(vld_d), 0);

    // R3: reset after activity clears the registered sum
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R3", int'(sum_g), 0);
    check("R3", int'(vld_g), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule